// File: doc/BRIEF.md
# Serial EEPROM Target Protocol Engine

This block is the target (slave) side of a two-wire serial memory. It oversamples the clock and data lines of the bus with the system clock and finds START and STOP conditions. It shifts in the first byte after a START and compares it with a fixed device code and three strap inputs. It answers on the data line by driving an open-drain output enable, which pulls the line low when set. A write command loads a 7-bit address pointer and then stores each following data byte into an internal 128 x 8 register file. A read command shifts bytes out of that file, most significant bit first, for as long as the master acknowledges.

A separate write-cycle timer sits next to the block. When the engine has taken in write data, it pulses `wcycle_start` at the STOP that follows. While the timer holds `cycle_busy` high, the engine refuses to acknowledge any control byte, so a master can poll for the end of the cycle. While `wr_protect` is high, write commands are still acknowledged, but the register file is left untouched.

The engine moves through these states: IDLE, CTRL (control byte in), CTRL_ACK, ADDR (word address in), ADDR_ACK, WDATA (write byte in), WDATA_ACK, RDATA (read byte out) and RACK (master acknowledge in). The transitions are:
- START, from any state, goes to CTRL.
- STOP, from any state, goes to IDLE.
- CTRL goes to CTRL_ACK on a matching control byte, and to IDLE on a mismatch or while busy.
- CTRL_ACK goes to RDATA or ADDR, according to the R/W bit.
- ADDR goes to ADDR_ACK, and ADDR_ACK goes to WDATA.
- WDATA goes to WDATA_ACK, and WDATA_ACK goes back to WDATA.
- RDATA goes to RACK after eight bits.
- RACK goes to RDATA when the master acknowledges, and to IDLE when it does not.

Top module: `serial_eeprom_target`

## Requirements
- R1: A falling data line while the clock is high is a START, and a rising data line while the clock is high is a STOP. A STOP returns the engine to idle, and after a STOP no byte is acknowledged until a new START.
- R2: The engine asserts `sda_oe` only while the sampled clock is low, and it holds the value steady through each clock-high phase.
- R3: A control byte is decoded as follows. Bits 7..4 must equal 1010 and bits 3..1 must equal `chip_sel[2:0]`. Bit 0 selects the operation: 1 is a read and 0 is a write. A matching byte is acknowledged by driving the line low for the whole ninth clock.
- R4: A control byte that does not match gets no acknowledge, and every later byte is ignored until the next START.
- R5: In a write command, the byte after the control byte is the word address, and its bits 6..0 load the pointer. The address byte and every data byte are acknowledged.
- R6: Each data byte is stored at the pointer. Only pointer bits 3..0 then increment, so a write wraps inside its 16-byte page.
- R7: While `wr_protect` is 1, write commands and data are acknowledged, but the register file is not modified.
- R8: While `cycle_busy` is 1, no control byte is acknowledged.
- R9: A read returns the byte at the pointer, most significant bit first, and then adds 1 to the pointer, modulo 128. A master acknowledge continues with the next byte. A master non-acknowledge leaves the line released until the next START.
- R10: A repeated START in any state, including partway through a byte, abandons the transfer without storing anything and begins control-byte reception again.
- R11: A STOP that ends a write in which at least one data byte was received pulses `wcycle_start` for one clock. This happens also when the write is protected. A transfer that is cut by a START does not pulse.
- R12: After reset, `sda_oe` and `wcycle_start` are 0 and the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired result) |
| chip_sel | input | 3 | Strap value the control byte bits 3..1 must match |
| wr_protect | input | 1 | 1 blocks all writes to the register file |
| cycle_busy | input | 1 | 1 while the write-cycle timer runs |
| sda_oe | output | 1 | 1 pulls the data line low |
| wcycle_start | output | 1 | One-clock pulse that starts the write-cycle timer |

## Verification
A wrong state register shows up as a missing or misplaced acknowledge. This is seen at the ninth clock of the byte in which the error happens, or as a read byte that comes out of the wrong address on the very next read. A pointer that wraps wrongly, or that increments the wrong bits, first becomes visible when the bytes are read back. For that reason, page wrap and modulo-128 wrap are read back across their boundaries. Errors in START and STOP handling show up within one byte, as an acknowledge where none is due, or the reverse.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } tgt_state_t;

    localparam logic [3:0] DEVICE_CODE = 4'b1010;

endpackage

// File: rtl/bus_sampler.sv
module bus_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_p;
    logic                   sda_p;

    // The idle bus is high on both lines, so reset to 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
            scl_p    <= scl_sync[SYNC_STAGES-1];
            sda_p    <= sda_sync[SYNC_STAGES-1];
        end
    end

    assign scl_s     = scl_sync[SYNC_STAGES-1];
    assign sda_s     = sda_sync[SYNC_STAGES-1];
    assign scl_rise  =  scl_s & ~scl_p;
    assign scl_fall  = ~scl_s &  scl_p;
    assign start_det =  scl_s &  scl_p &  sda_p & ~sda_s;
    assign stop_det  =  scl_s &  scl_p & ~sda_p &  sda_s;

endmodule

// File: rtl/eeprom_regfile.sv
module eeprom_regfile #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/serial_eeprom_target.sv
module serial_eeprom_target
    import eeprom_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int PAGE_W      = 4,
    parameter int SEL_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [SEL_W-1:0] chip_sel,
    input  logic             wr_protect,
    input  logic             cycle_busy,
    output logic             sda_oe,
    output logic             wcycle_start
);

    localparam int                BIT_W    = $clog2(DATA_W + 1);
    localparam logic [BIT_W-1:0]  FULL_CNT = BIT_W'(DATA_W);
    localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(DATA_W - 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    tgt_state_t        state_q, state_nxt;
    logic [DATA_W-1:0] rx_q;
    logic [DATA_W-1:0] tx_q;
    logic [BIT_W-1:0]  bit_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] page_next;
    logic              mack_q;
    logic              wrote_q;
    logic              byte_done;
    logic              ctrl_match;
    logic              mem_we;
    logic [DATA_W-1:0] mem_rd;

    bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    eeprom_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .we    (mem_we),
        .addr  (ptr_q),
        .wdata (rx_q),
        .rdata (mem_rd)
    );

    assign byte_done  = (bit_q == FULL_CNT);
    assign ctrl_match = (rx_q[DATA_W-1 -: 4] == DEVICE_CODE) &&
                        (rx_q[SEL_W:1] == chip_sel);
    // Inside a page, only the low PAGE_W bits of the pointer count.
    assign page_next  = {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + 1'b1};
    assign mem_we     = (state_q == ST_WDATA) && scl_fall && byte_done &&
                        !wr_protect && !start_det && !stop_det;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Transition logic: START and STOP win over clock edges
    always_comb begin
        state_nxt = state_q;
        if (start_det) begin
            state_nxt = ST_CTRL;
        end else if (stop_det) begin
            state_nxt = ST_IDLE;
        end else if (scl_fall) begin
            unique case (state_q)
                ST_IDLE:      state_nxt = ST_IDLE;
                ST_CTRL:      if (byte_done) state_nxt = (ctrl_match && !cycle_busy) ? ST_CTRL_ACK : ST_IDLE;
                ST_CTRL_ACK:  state_nxt = rx_q[0] ? ST_RDATA : ST_ADDR;
                ST_ADDR:      if (byte_done) state_nxt = ST_ADDR_ACK;
                ST_ADDR_ACK:  state_nxt = ST_WDATA;
                ST_WDATA:     if (byte_done) state_nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: state_nxt = ST_WDATA;
                ST_RDATA:     if (bit_q == LAST_BIT) state_nxt = ST_RACK;
                ST_RACK:      state_nxt = mack_q ? ST_RDATA : ST_IDLE;
                default:      state_nxt = ST_IDLE;
            endcase
        end
    end

    // Datapath: shift registers, bit counter, address pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q   <= '0;
            tx_q   <= '0;
            bit_q  <= '0;
            ptr_q  <= '0;
            mack_q <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_q <= '0;
        end else if (scl_rise) begin
            unique case (state_q)
                ST_CTRL, ST_ADDR, ST_WDATA: begin
                    rx_q  <= {rx_q[DATA_W-2:0], sda_s};
                    bit_q <= bit_q + 1'b1;
                end
                ST_RACK: mack_q <= ~sda_s;
                default: ;
            endcase
        end else if (scl_fall) begin
            unique case (state_q)
                ST_ADDR:  if (byte_done) ptr_q <= rx_q[ADDR_W-1:0];
                ST_WDATA: if (byte_done) ptr_q <= page_next;
                ST_CTRL_ACK: begin
                    bit_q <= '0;
                    if (rx_q[0]) begin
                        tx_q  <= mem_rd;
                        ptr_q <= ptr_q + 1'b1;
                    end
                end
                ST_ADDR_ACK, ST_WDATA_ACK: bit_q <= '0;
                ST_RDATA: begin
                    if (bit_q == LAST_BIT) begin
                        bit_q <= '0;
                    end else begin
                        tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
                        bit_q <= bit_q + 1'b1;
                    end
                end
                ST_RACK: begin
                    bit_q <= '0;
                    if (mack_q) begin
                        tx_q  <= mem_rd;
                        ptr_q <= ptr_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs: line drive, write-cycle request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe       <= 1'b0;
            wcycle_start <= 1'b0;
            wrote_q      <= 1'b0;
        end else begin
            wcycle_start <= stop_det && wrote_q;
            if (start_det || stop_det) begin
                sda_oe  <= 1'b0;
                wrote_q <= 1'b0;
            end else if (scl_fall) begin
                unique case (state_q)
                    ST_CTRL:     sda_oe <= byte_done && ctrl_match && !cycle_busy;
                    ST_ADDR:     sda_oe <= byte_done;
                    ST_WDATA: begin
                        sda_oe <= byte_done;
                        if (byte_done) wrote_q <= 1'b1;
                    end
                    ST_CTRL_ACK: sda_oe <= rx_q[0] & ~mem_rd[DATA_W-1];
                    ST_RDATA:    sda_oe <= (bit_q == LAST_BIT) ? 1'b0 : ~tx_q[DATA_W-2];
                    ST_RACK:     sda_oe <= mack_q & ~mem_rd[DATA_W-1];
                    default:     sda_oe <= 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/eeprom_target_checker.sv
module eeprom_target_checker
    import eeprom_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input tgt_state_t state_q,
    input logic       scl_s,
    input logic       start_det,
    input logic       sda_oe,
    input logic       mem_we,
    input logic       wr_protect,
    input logic       cycle_busy,
    input logic       wcycle_start
);

    AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s); // R2

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sda_oe); // R4

    AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_busy && state_q == ST_CTRL) |=> !sda_oe); // R8

    AST_WP_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_protect |-> !mem_we); // R7

    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state_q == ST_CTRL)); // R10

    AST_WCYCLE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wcycle_start |=> !wcycle_start); // R11

endmodule

bind serial_eeprom_target eeprom_target_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state_q      (state_q),
    .scl_s        (scl_s),
    .start_det    (start_det),
    .sda_oe       (sda_oe),
    .mem_we       (mem_we),
    .wr_protect   (wr_protect),
    .cycle_busy   (cycle_busy),
    .wcycle_start (wcycle_start)
);

// File: tb/tb_serial_eeprom_target.sv
module tb_serial_eeprom_target;

    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [2:0] chip_sel = 3'b101;
    logic wr_protect = 1'b0;
    logic cycle_busy = 1'b0;
    logic sda_oe;
    logic wcycle_start;
    logic sda_line;

    int n_tests = 0;
    int n_fail  = 0;
    int wc_count = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    serial_eeprom_target dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_line),
        .chip_sel     (chip_sel),
        .wr_protect   (wr_protect),
        .cycle_busy   (cycle_busy),
        .sda_oe       (sda_oe),
        .wcycle_start (wcycle_start)
    );

    always_ff @(posedge clk) if (wcycle_start) wc_count <= wc_count + 1;

    // {control byte, expected ack}; chip_sel = 101
    localparam logic [8:0] CTRL_VEC [8] = '{
        {8'hAA, 1'b1}, {8'hA0, 1'b0}, {8'hA2, 1'b0}, {8'hBA, 1'b0},
        {8'h2A, 1'b0}, {8'hAE, 1'b0}, {8'hA8, 1'b0}, {8'hEA, 1'b0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic waitq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; waitq(1);
        scl_m = 1'b1; waitq(2);
        sda_m = 1'b0; waitq(2);
        scl_m = 1'b0; waitq(1);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; waitq(1);
        scl_m = 1'b1; waitq(2);
        sda_m = 1'b1; waitq(2);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; waitq(1);
            scl_m = 1'b1; waitq(2);
            scl_m = 1'b0; waitq(1);
        end
    endtask

    // Sends a byte; acked = line low over the whole 9th high phase
    task automatic send_byte(input logic [7:0] b, output bit acked);
        logic a1, a2;
        send_bits(b, 8);
        sda_m = 1'b1; waitq(1);
        scl_m = 1'b1;
        @(negedge clk); a1 = sda_line;
        repeat (2 * Q - 2) @(negedge clk); a2 = sda_line;
        @(negedge clk);
        scl_m = 1'b0; waitq(1);
        acked = !a1 && !a2;
        check(a1 == a2, "R2 ack stable over high phase", a2, a1);
    endtask

    task automatic recv_byte(input bit m_ack, output logic [7:0] b, output logic oe9);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            waitq(1);
            scl_m = 1'b1; waitq(1);
            b[i] = sda_line; waitq(1);
            scl_m = 1'b0;
        end
        sda_m = m_ack ? 1'b0 : 1'b1; waitq(1);
        scl_m = 1'b1; waitq(1);
        oe9 = sda_oe; waitq(1);
        scl_m = 1'b0; waitq(1);
        sda_m = 1'b1;
    endtask

    task automatic write_seq(input logic [6:0] addr, input logic [7:0] d [], input string req);
        bit ak;
        i2c_start();
        send_byte(8'hAA, ak); check(ak, {req, " ctrl ack"}, ak, 1);
        send_byte({1'b0, addr}, ak); check(ak, "R5 address ack", ak, 1);
        foreach (d[i]) begin
            send_byte(d[i], ak); check(ak, "R5 data ack", ak, 1);
        end
        i2c_stop();
    endtask

    task automatic set_ptr(input logic [6:0] addr);
        bit ak;
        i2c_start();
        send_byte(8'hAA, ak);
        send_byte({1'b0, addr}, ak);
    endtask

    task automatic read_check(input logic [6:0] addr, input logic [7:0] exp [], input string req);
        bit ak;
        logic [7:0] b;
        logic oe9;
        set_ptr(addr);
        i2c_start();
        send_byte(8'hAB, ak); check(ak, "R3 read ctrl ack", ak, 1);
        foreach (exp[i]) begin
            recv_byte(i != exp.size() - 1, b, oe9);
            check(b == exp[i], req, b, exp[i]);
        end
        check(oe9 == 1'b0, "R9 line released after nack", oe9, 0);
        i2c_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bit ak;
        int wc0;
        logic [7:0] b;
        logic oe9;
        repeat (5) @(negedge clk);
        check(sda_oe == 1'b0, "R12 reset sda_oe", sda_oe, 0);
        check(wcycle_start == 1'b0, "R12 reset wcycle_start", wcycle_start, 0);
        rst_n = 1'b1;
        waitq(2);
        check(sda_oe == 1'b0, "R12 idle after reset", sda_oe, 0);

        // Control byte decode table (R3, R4)
        foreach (CTRL_VEC[v]) begin
            i2c_start();
            send_byte(CTRL_VEC[v][8:1], ak);
            check(ak == CTRL_VEC[v][0], "R3 control decode", ak, CTRL_VEC[v][0]);
            if (!CTRL_VEC[v][0]) begin
                send_byte(8'hAA, ak);
                check(!ak, "R4 ignored until START", ak, 0);
            end
            i2c_stop();
        end

        // Byte writes and stop pulse (R5, R11)
        wc0 = wc_count;
        write_seq(7'h10, '{8'h5A}, "R5");
        waitq(1);
        check(wc_count == wc0 + 1, "R11 write cycle pulse", wc_count, wc0 + 1);
        write_seq(7'h00, '{8'h33}, "R5");
        write_seq(7'h7F, '{8'h77}, "R5");
        write_seq(7'h40, '{8'h99}, "R5");

        // Random read through repeated START (R9, R10)
        read_check(7'h10, '{8'h5A}, "R9 random read");

        // Page write wrapping inside 16-byte page (R6)
        write_seq(7'h1E, '{8'h01, 8'h02, 8'h03, 8'h04}, "R6");
        read_check(7'h1E, '{8'h01, 8'h02}, "R6 page start bytes");
        read_check(7'h10, '{8'h03, 8'h04}, "R6 page wrap bytes");

        // Sequential read wrapping modulo 128 (R9)
        read_check(7'h7F, '{8'h77, 8'h33}, "R9 read wrap 7F->00");

        // Write protect (R7, R11)
        wr_protect = 1'b1;
        wc0 = wc_count;
        write_seq(7'h10, '{8'hEE}, "R7");
        waitq(1);
        check(wc_count == wc0 + 1, "R11 pulse when protected", wc_count, wc0 + 1);
        wr_protect = 1'b0;
        read_check(7'h10, '{8'h03}, "R7 protected byte unchanged");

        // Busy refuses ack (R8)
        cycle_busy = 1'b1;
        i2c_start();
        send_byte(8'hAA, ak); check(!ak, "R8 no ack while busy", ak, 0);
        i2c_stop();
        cycle_busy = 1'b0;
        i2c_start();
        send_byte(8'hAA, ak); check(ak, "R8 ack after busy ends", ak, 1);
        i2c_stop();

        // Repeated START mid-byte aborts without storing (R10, R11)
        wc0 = wc_count;
        set_ptr(7'h40);
        send_bits(8'h0F, 4);
        i2c_start();
        send_byte(8'hAB, ak); check(ak, "R10 restart ctrl ack", ak, 1);
        recv_byte(1'b0, b, oe9);
        check(b == 8'h99, "R10 abort stored nothing", b, 8'h99);
        i2c_stop();
        waitq(1);
        check(wc_count == wc0, "R11 no pulse after aborted write", wc_count, wc0);

        // STOP returns to idle (R1)
        set_ptr(7'h20);
        i2c_stop();
        send_byte(8'hAA, ak); check(!ak, "R1 no ack after STOP", ak, 0);
        i2c_stop();

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule